// File: doc/BRIEF.md
# Polled ADC Controller Register Front-End

This block is the register-side controller for a multi-input analog-to-digital converter that software drives by polling. A processor reaches it through a 32-bit register bus with select and enable phases, where an access takes place in a cycle with `psel` and `penable` both high. A read of the result register launches the next conversion. The block delays that launch until the input routing has settled and the minimum spacing between conversions has passed. It then pulses `adc_start` to the converter and captures `adc_sample` when `adc_done` arrives. At that point it raises a ready flag, which shows in the result word and can also drive `irq` through an enable bit.

The register that selects the input routing is protected. A write to it takes effect only when the bus access just before it wrote the unlock key to the lock register. When a new routing value is accepted, a settling timer restarts. Any conversion requested while that timer runs is held until it expires.

Top module: `adc_poll_frontend`

## Requirements
- R1: Register offsets: result at 0x08, switch at 0x18, lock at 0x20, interrupt enable at 0x24. Every other offset reads zero, and the lock register reads zero. After reset the switch and enable registers read zero, `irq` is low and `adc_start` stays low until a result read.
- R2: A result read returns the ready flag in bit 31, zeros in bits 30:16, and the latest sample as 16-bit two's complement in bits 15:0. While the flag is clear, bits 15:0 read zero.
- R3: A switch write is accepted only when the immediately preceding bus access wrote exactly 0x000000AA to the lock register. The switch register keeps the low 12 bits of the write and reads them back zero-extended. A switch write without that key is ignored.
- R4: Every bus access other than a switch write re-arms the lock. This includes reads and lock writes of any other value. A switch write always consumes the unlock, whether or not it was accepted.
- R5: A result read with no conversion pending or in progress clears the flag and the sample field and requests one conversion. `adc_start` is a single-cycle pulse. A result read while a conversion is pending or in progress returns a clear flag and requests nothing.
- R6: An accepted switch write that changes the stored value restarts settling. No `adc_start` occurs earlier than SETTLE_CYC cycles after that write's access cycle, and a held request fires exactly then. Writing the same value does not restart settling, and a request on a settled, idle block fires in the cycle after the read.
- R7: Successive `adc_start` pulses are at least GAP_CYC cycles apart. A held request fires exactly when that window ends.
- R8: An `adc_done` pulse while a conversion is in progress stores `adc_sample` and sets the ready flag from the next cycle. An `adc_done` pulse at any other time changes nothing.
- R9: The enable register stores only bit 11 and reads back 0x800 or 0. `irq` is high exactly when the ready flag and that bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable; an access is a cycle with psel and penable high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| adc_start | output | 1 | One-cycle request to begin a conversion |
| adc_done | input | 1 | One-cycle pulse when the converter has a sample |
| adc_sample | input | 16 | Signed sample, valid with adc_done |
| irq | output | 1 | Ready flag gated by the enable bit |

## Verification
The assertions assume that the converter answers each `adc_start` with exactly one `adc_done` and never asserts `adc_done` on its own. The one exception is the deliberate stray pulse. They also assume that bus accesses hold their control and data stable through the access cycle. The bench models the converter with a fixed latency that is well below the conversion spacing. It injects a single stray `adc_done` only while the block is idle, and it draws samples within the nominal range of -25000 to +25000. Random bus traffic on the lock path uses only the defined offsets, so the bench can follow the expected lock state access by access.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SWITCH = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 8'h24;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_00AA;
  localparam int          IRQEN_BIT  = 11;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_RESULT,
    RS_SWITCH,
    RS_LOCK,
    RS_IRQEN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_RESULT: s = RS_RESULT;
      OFS_SWITCH: s = RS_SWITCH;
      OFS_LOCK:   s = RS_LOCK;
      OFS_IRQEN:  s = RS_IRQEN;
      default:    s = RS_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/adcfe_lock_gate.sv
module adcfe_lock_gate
  import adcfe_pkg::*;
#(
  parameter int SW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            acc_wr,
  input  reg_sel_e        sel,
  input  logic [31:0]     wdata,
  output logic [SW_W-1:0] sw_value,
  output logic            sw_changed
);

  logic            unlocked_q, unlocked_d;
  logic [SW_W-1:0] sw_q, sw_d;
  logic            sw_wr, key_wr, commit;

  always_comb begin
    sw_wr      = acc && acc_wr && (sel == RS_SWITCH);
    key_wr     = acc && acc_wr && (sel == RS_LOCK) && (wdata == UNLOCK_KEY);
    commit     = sw_wr && unlocked_q;
    sw_changed = commit && (wdata[SW_W-1:0] != sw_q);
    unlocked_d = acc ? key_wr : unlocked_q;
    sw_d       = commit ? wdata[SW_W-1:0] : sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      sw_q       <= '0;
    end else begin
      unlocked_q <= unlocked_d;
      sw_q       <= sw_d;
    end
  end

  assign sw_value = sw_q;

  // R3
  sw_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q != $past(sw_q)) |-> $past(sw_wr && unlocked_q));

endmodule

// File: rtl/adcfe_conv_seq.sv
module adcfe_conv_seq #(
  parameter int SMP_W      = 16,
  parameter int SETTLE_CYC = 40,
  parameter int GAP_CYC    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rd,
  input  logic             sw_changed,
  input  logic             adc_done,
  input  logic [SMP_W-1:0] adc_sample,
  output logic             adc_start,
  output logic             ready,
  output logic [SMP_W-1:0] sample
);

  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam int GP_W = $clog2(GAP_CYC + 1);

  logic [ST_W-1:0]  settle_q, settle_d;
  logic [GP_W-1:0]  gap_q, gap_d;
  logic             pending_q, pending_d;
  logic             busy_q, busy_d;
  logic             ready_q, ready_d;
  logic [SMP_W-1:0] data_q, data_d;
  logic             fire, accept, done_ok;

  always_comb begin
    fire    = pending_q && (settle_q == '0) && (gap_q == '0) && !busy_q;
    accept  = trig_rd && !pending_q && !busy_q;
    done_ok = adc_done && busy_q;

    if (sw_changed)          settle_d = ST_W'(SETTLE_CYC - 1);
    else if (settle_q != '0) settle_d = settle_q - 1'b1;
    else                     settle_d = settle_q;

    if (fire)             gap_d = GP_W'(GAP_CYC - 1);
    else if (gap_q != '0) gap_d = gap_q - 1'b1;
    else                  gap_d = gap_q;

    pending_d = pending_q;
    if (accept)    pending_d = 1'b1;
    else if (fire) pending_d = 1'b0;

    busy_d = busy_q;
    if (fire)         busy_d = 1'b1;
    else if (done_ok) busy_d = 1'b0;

    ready_d = ready_q;
    data_d  = data_q;
    if (accept) begin
      ready_d = 1'b0;
      data_d  = '0;
    end else if (done_ok) begin
      ready_d = 1'b1;
      data_d  = adc_sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q  <= '0;
      gap_q     <= '0;
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      ready_q   <= 1'b0;
      data_q    <= '0;
    end else begin
      settle_q  <= settle_d;
      gap_q     <= gap_d;
      pending_q <= pending_d;
      busy_q    <= busy_d;
      ready_q   <= ready_d;
      data_q    <= data_d;
    end
  end

  assign adc_start = fire;
  assign ready     = ready_q;
  assign sample    = data_q;

  // Checker-side window counters, saturating at the parameter value
  logic [ST_W-1:0] since_chg_q;
  logic [GP_W-1:0] since_start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_chg_q   <= ST_W'(SETTLE_CYC);
      since_start_q <= GP_W'(GAP_CYC);
    end else begin
      if (sw_changed)                            since_chg_q <= ST_W'(1);
      else if (since_chg_q != ST_W'(SETTLE_CYC)) since_chg_q <= since_chg_q + 1'b1;
      if (adc_start)                             since_start_q <= GP_W'(1);
      else if (since_start_q != GP_W'(GAP_CYC))  since_start_q <= since_start_q + 1'b1;
    end
  end

  // R6
  settle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (since_chg_q >= ST_W'(SETTLE_CYC)));

  // R7
  rate_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (since_start_q >= GP_W'(GAP_CYC)));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(adc_done) && (data_q == $past(adc_sample))));

endmodule

// File: rtl/adc_poll_frontend.sv
module adc_poll_frontend
  import adcfe_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int SW_W       = 12,
  parameter int SETTLE_CYC = 40,
  parameter int GAP_CYC    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [7:0]       paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             adc_start,
  input  logic             adc_done,
  input  logic [SMP_W-1:0] adc_sample,
  output logic             irq
);

  localparam int PAD_W = 31 - SMP_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             acc, trig_rd, ie_wr;
  reg_sel_e         sel;
  logic             ie_q, ie_d;
  logic [SW_W-1:0]  sw_value;
  logic             sw_changed, ready;
  logic [SMP_W-1:0] sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    sel     = decode_ofs(paddr);
    acc     = psel && penable;
    trig_rd = acc && !pwrite && (sel == RS_RESULT);
    ie_wr   = acc && pwrite && (sel == RS_IRQEN);
    ie_d    = ie_wr ? pwdata[IRQEN_BIT] : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ie_q <= 1'b0;
    else          ie_q <= ie_d;
  end

  adcfe_lock_gate #(.SW_W(SW_W)) i_lock (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .acc        (acc),
    .acc_wr     (pwrite),
    .sel        (sel),
    .wdata      (pwdata),
    .sw_value   (sw_value),
    .sw_changed (sw_changed)
  );

  adcfe_conv_seq #(
    .SMP_W      (SMP_W),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .trig_rd    (trig_rd),
    .sw_changed (sw_changed),
    .adc_done   (adc_done),
    .adc_sample (adc_sample),
    .adc_start  (adc_start),
    .ready      (ready),
    .sample     (sample)
  );

  always_comb begin
    prdata = '0;
    case (sel)
      RS_RESULT: prdata = {ready, {PAD_W{1'b0}}, sample};
      RS_SWITCH: prdata = {{(32-SW_W){1'b0}}, sw_value};
      RS_IRQEN:  prdata[IRQEN_BIT] = ie_q;
      default:   prdata = '0;
    endcase
  end

  assign irq = ready && ie_q;

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> ($past(adc_done) || $past(ie_wr && pwdata[IRQEN_BIT])));

endmodule

// File: tb/test_adc_poll_frontend.sv
`timescale 1ns/1ps
module test_adc_poll_frontend;

  localparam int SETTLE = 40;
  localparam int GAP    = 24;
  localparam int LAT    = 5;
  localparam logic [7:0] A_RES = 8'h08, A_SW = 8'h18, A_LK = 8'h20, A_IE = 8'h24;

  logic        clk, rst_n, psel, penable, pwrite, adc_done, adc_start, irq;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [15:0] adc_sample;

  adc_poll_frontend #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP)) i_adc_poll_frontend (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .adc_start(adc_start),
    .adc_done(adc_done), .adc_sample(adc_sample), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int last_start = -1000, last_chg = -1000, n_starts = 0;
  int last_val = 0, next_val = 0;
  bit use_next = 0, stray = 0;
  bit exp_unl = 0;
  logic [11:0] exp_sw = '0;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] res_word(input int v);
    return {1'b1, 15'b0, 16'(v)};
  endfunction

  function automatic logic [11:0] route(input int i);
    case (i)
      0: return 12'h608; 1: return 12'h680; 2: return 12'h640; 3: return 12'h620;
      4: return 12'h610; 5: return 12'h601; 6: return 12'h602; default: return 12'h604;
    endcase
  endfunction

  // One bus access: setup cycle, then access cycle; tracks the lock model
  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] r, output int ac);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; ac = cyc;
    #5 r = prdata;
    @(posedge clk);
    #1 psel = 0; penable = 0; pwrite = 0;
    if (wr && a == A_SW) begin
      if (exp_unl && d[11:0] != exp_sw) begin exp_sw = d[11:0]; last_chg = ac; end
      exp_unl = 0;
    end else begin
      exp_unl = (wr && a == A_LK && d == 32'hAA);
    end
  endtask

  task automatic poll(output logic [31:0] r, output int ac);
    for (int i = 0; i < 100; i++) begin
      bus(0, A_RES, 0, r, ac);
      if (r[31]) break;
    end
  endtask

  task automatic wait_idle();
    repeat (SETTLE + GAP + LAT + 10) @(negedge clk);
  endtask

  // Converter model
  initial begin
    adc_done = 0; adc_sample = 0;
    forever begin
      @(negedge clk);
      if (adc_start === 1'b1) begin
        int v;
        chk("R7", 32'(cyc - last_start >= GAP), 1);
        chk("R6", 32'(cyc - last_chg >= SETTLE), 1);
        last_start = cyc; n_starts++;
        if (use_next) begin v = next_val; use_next = 0; end
        else v = int'($urandom_range(50000)) - 25000;
        repeat (LAT) @(negedge clk);
        adc_sample = 16'(v); adc_done = 1;
        @(negedge clk);
        adc_done = 0; last_val = v;
      end else if (stray) begin
        adc_sample = 16'h1234; adc_done = 1;
        @(negedge clk);
        adc_done = 0; stray = 0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int ac, ps, exp_s, n0, ac2;
    void'($urandom(32'd1234));
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state and decode
    chk("R1", irq, 0);
    chk("R1", adc_start, 0);
    bus(0, A_SW, 0, r, ac);  chk("R1", r, 0);
    bus(0, A_IE, 0, r, ac);  chk("R1", r, 0);
    bus(0, A_LK, 0, r, ac);  chk("R1", r, 0);
    bus(0, 8'h30, 0, r, ac); chk("R1", r, 0);
    bus(0, 8'h04, 0, r, ac); chk("R1", r, 0);
    chk("R1", 32'(n_starts), 0);

    // R3/R4 directed lock cases
    bus(1, A_SW, 32'h608, r, ac); bus(0, A_SW, 0, r, ac); chk("R3", r, 32'h0);
    bus(1, A_LK, 32'hAA, r, ac); bus(1, A_SW, 32'h608, r, ac);
    bus(0, A_SW, 0, r, ac); chk("R3", r, 32'h608);
    bus(1, A_LK, 32'hAA, r, ac); bus(1, A_IE, 0, r, ac); bus(1, A_SW, 32'h680, r, ac);
    bus(0, A_SW, 0, r, ac); chk("R4", r, 32'h608);
    bus(1, A_LK, 32'hAA, r, ac); bus(1, A_LK, 32'h55, r, ac); bus(1, A_SW, 32'h680, r, ac);
    bus(0, A_SW, 0, r, ac); chk("R4", r, 32'h608);
    bus(1, A_LK, 32'hAA, r, ac); bus(0, A_SW, 0, r, ac); bus(1, A_SW, 32'h680, r, ac);
    bus(0, A_SW, 0, r, ac); chk("R4", r, 32'h608);
    bus(1, A_LK, 32'hAA, r, ac); bus(1, A_SW, 32'hFFFF_F680, r, ac);
    bus(1, A_SW, 32'h640, r, ac);
    bus(0, A_SW, 0, r, ac); chk("R3", r, 32'h680);

    // R6 held request fires exactly when settling ends; R2/R5 read while empty
    bus(0, A_RES, 0, r, ac); chk("R2", r, 32'h0);
    bus(0, A_RES, 0, r, ac); chk("R5", r, 32'h0);
    repeat (SETTLE + 5) @(negedge clk);
    chk("R6", 32'(last_start), 32'(last_chg + SETTLE));
    chk("R5", 32'(n_starts), 1);

    // R2/R8 result capture; R7 held request waits for the rate window
    poll(r, ac);
    ps = last_start;
    chk("R8", r, res_word(last_val));
    n0 = n_starts;
    bus(0, A_RES, 0, r, ac2); chk("R5", r, 32'h0);
    bus(0, A_RES, 0, r, ac2); chk("R5", r, 32'h0);
    exp_s = (ac + 1 > ps + GAP) ? ac + 1 : ps + GAP;
    poll(r, ac2);
    chk("R7", 32'(last_start), 32'(exp_s));
    chk("R5", 32'(n_starts), 32'(n0 + 1));
    chk("R2", r, res_word(last_val));

    // R6 same-value write does not restart settling
    wait_idle();
    bus(1, A_LK, 32'hAA, r, ac); bus(1, A_SW, 32'h680, r, ac);
    bus(0, A_RES, 0, r, ac);
    chk("R2", r, res_word(last_val));
    repeat (3) @(negedge clk);
    chk("R6", 32'(last_start), 32'(ac + 1));

    // R9 interrupt enable
    wait_idle();
    bus(1, A_IE, 32'hFFFF_FFFF, r, ac);
    bus(0, A_IE, 0, r, ac); chk("R9", r, 32'h800);
    @(negedge clk); chk("R9", irq, 1);
    bus(0, A_RES, 0, r, ac);
    @(negedge clk); chk("R9", irq, 0);
    wait_idle(); chk("R9", irq, 1);
    bus(1, A_IE, 32'h0, r, ac);
    @(negedge clk); chk("R9", irq, 0);
    bus(0, A_IE, 0, r, ac); chk("R9", r, 32'h0);

    // R8 stray done while idle is ignored
    stray = 1;
    repeat (4) @(negedge clk);
    bus(0, A_RES, 0, r, ac); chk("R8", r, res_word(last_val));

    // R2 corner samples
    for (int k = 0; k < 4; k++) begin
      int cv;
      cv = (k == 0) ? 25000 : (k == 1) ? -25000 : (k == 2) ? 0 : -1;
      wait_idle();
      next_val = cv; use_next = 1;
      bus(0, A_RES, 0, r, ac);
      wait_idle();
      bus(0, A_RES, 0, r, ac); chk("R2", r, res_word(cv));
      use_next = 0;
    end

    // R8 random samples through polling
    for (int k = 0; k < 12; k++) begin
      poll(r, ac); chk("R8", r, res_word(last_val));
    end

    // R3/R4 constrained random lock traffic
    wait_idle();
    for (int k = 0; k < 60; k++) begin
      int op;
      op = int'($urandom_range(4));
      case (op)
        0: bus(1, A_LK, 32'hAA, r, ac);
        1: bus(1, A_LK, 32'hAB + $urandom_range(100), r, ac);
        2: bus(1, A_SW, {20'h0, route(int'($urandom_range(7)))}, r, ac);
        3: bus(1, A_IE, 32'h0, r, ac);
        default: begin bus(0, A_SW, 0, r, ac); chk("R3", r, {20'h0, exp_sw}); end
      endcase
    end
    bus(0, A_SW, 0, r, ac); chk("R4", r, {20'h0, exp_sw});

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule